// File: doc/BRIEF.md
# Full-Search SAD Motion Estimator

This block finds, for one square block of luminance, the displacement inside a search window that matches it best. For every candidate vector in a symmetric range of minus RANGE to plus RANGE-1 on both axes it adds up the absolute pixel differences. There is one accumulating processing element per candidate, so every reference pixel updates all candidates in the same clock. With the default parameters the block is 16x16 pixels, the range is -8..+7 and there are 256 elements.

A bidirectional estimate is formed in one pass. The previous image (backward) window and the next image (forward) window are both loaded, and the reference block then streams through both element arrays at once. A final comparator keeps whichever direction gives the lower SAD. After a scene cut, the image that belongs to the other scene produces large SADs and loses, so the block is taken from the matching side.

All three streams use valid/ready. A beat transfers on a rising edge where both valid and ready are high. A producer may drop valid at any time, and the block only raises each ready during its own phase: window loading, then reference input, then result output. A result is held with a stable payload until `res_ready` takes it, and no new window beat is accepted until then.

Top module: `sad_motion_est`

## Requirements
- R1: After reset `res_valid` is 0, `win_ready` is 1 and `ref_ready` is 0.
- R2: The window phase accepts 2*W*W beats, where W = BLK+2*RANGE-1. The backward window comes first and the forward window second, each in column-major order: beat j of a window is column j/W, row j%W. `ref_ready` is 0 during this phase.
- R3: The reference phase accepts BLK*BLK beats in column-major order: beat i is column i/BLK, row i%BLK. It starts on the clock after the last window beat. `win_ready` and `res_valid` are 0 during this phase.
- R4: The SAD of candidate (dx,dy) is the exact sum over the block of |ref(x,y) - win(x+dx+RANGE, y+dy+RANGE)|. It does not overflow for any pixel values.
- R5: Within a direction, the winner is the candidate with the smallest SAD. Ties go to the lowest index k = (dy+RANGE)*2*RANGE + (dx+RANGE).
- R6: Edge flags are sampled with the first reference beat. With `edge_left` set, dx<0 is illegal. With `edge_right` set, dx>0 is illegal. With `edge_top` set, dy<0 is illegal. With `edge_bottom` set, dy>0 is illegal. Illegal candidates count as the all-ones SAD and are never reported. The zero vector is always legal.
- R7: The result takes the forward estimate only if its SAD is strictly lower than the backward one. `res_dir` is 1 for forward and 0 for backward.
- R8: `res_dx` and `res_dy` are two's complement. While `res_valid` is high and `res_ready` is low, the result payload stays stable and `win_ready` stays low.
- R9: Idle cycles on either input stream and back-pressure on the output do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | 1 | Search window beat valid |
| win_ready | output | 1 | Window phase active |
| win_pix | input | PIX_W | Search window pixel |
| ref_valid | input | 1 | Reference beat valid |
| ref_ready | output | 1 | Reference phase active |
| ref_pix | input | PIX_W | Reference block pixel |
| edge_left | input | 1 | Block touches the left image border |
| edge_right | input | 1 | Block touches the right image border |
| edge_top | input | 1 | Block touches the top image border |
| edge_bottom | input | 1 | Block touches the bottom image border |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumer ready |
| res_dx | output | $clog2(RANGE)+1 | Horizontal vector, signed |
| res_dy | output | $clog2(RANGE)+1 | Vertical vector, signed |
| res_sad | output | SAD_W | SAD of the chosen vector |
| res_dir | output | 1 | 1 forward, 0 backward |

## Verification
The bench builds the block with a 4x4 block, a range of -2..+1, 8-bit pixels and a 13-bit SAD. That gives 16 candidates per direction and a 7x7 window, so every candidate position, each edge combination and exhaustive tie cases can be driven in a few hundred cycles. The same configuration makes the worst-case accumulation (all-ones reference against an all-zero window) reachable, and it is checked against the SAD width. The same 16-candidate set is also small enough for the bench to recompute every SAD on its own.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [1:0] {
    PH_LOAD = 2'd0,
    PH_REF  = 2'd1,
    PH_SCAN = 2'd2,
    PH_OUT  = 2'd3
  } me_phase_e;

  typedef struct packed {
    logic l;
    logic r;
    logic t;
    logic b;
  } me_edge_t;
endpackage

// File: rtl/sad_pe.sv
module sad_pe #(
  parameter int PIX_W = 10,
  parameter int SAD_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             acc_en,
  input  logic [PIX_W-1:0] ref_pix,
  input  logic [PIX_W-1:0] win_pix,
  output logic [SAD_W-1:0] sad
);
  logic [PIX_W-1:0] adiff;

  assign adiff = (ref_pix >= win_pix) ? (ref_pix - win_pix) : (win_pix - ref_pix);

  always_ff @(posedge clk) begin
    if (!rst_n)      sad <= '0;
    else if (clr)    sad <= '0;
    else if (acc_en) sad <= sad + {{(SAD_W-PIX_W){1'b0}}, adiff};
  end
endmodule

// File: rtl/sad_cand_array.sv
module sad_cand_array #(
  parameter int BLK   = 16,
  parameter int RANGE = 8,
  parameter int PIX_W = 10,
  parameter int SAD_W = 19,
  localparam int SPAN = 2*RANGE,
  localparam int N    = SPAN*SPAN,
  localparam int WIN  = BLK+SPAN-1,
  localparam int WW   = WIN*WIN,
  localparam int AW   = $clog2(WW),
  localparam int XW   = $clog2(BLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIX_W-1:0] wr_pix,
  input  logic             clr,
  input  logic             acc_en,
  input  logic [XW-1:0]    ref_x,
  input  logic [XW-1:0]    ref_y,
  input  logic [PIX_W-1:0] ref_pix,
  output logic [SAD_W-1:0] sad [N]
);
  // search window, column-major storage
  logic [PIX_W-1:0] win_mem [WW];

  always_ff @(posedge clk) begin
    if (wr_en) win_mem[wr_addr] <= wr_pix;
  end

  for (genvar gk = 0; gk < N; gk++) begin : g_cand
    localparam int CX = gk % SPAN;
    localparam int CY = gk / SPAN;
    logic [AW-1:0] rd_addr;

    assign rd_addr = AW'((int'(ref_x) + CX) * WIN + int'(ref_y) + CY);

    sad_pe #(.PIX_W(PIX_W), .SAD_W(SAD_W)) u_pe (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .acc_en  (acc_en),
      .ref_pix (ref_pix),
      .win_pix (win_mem[rd_addr]),
      .sad     (sad[gk])
    );
  end
endmodule

// File: rtl/sad_min_scan.sv
module sad_min_scan
  import sad_pkg::*;
#(
  parameter int RANGE = 8,
  parameter int SAD_W = 19,
  localparam int SPAN = 2*RANGE,
  localparam int N    = SPAN*SPAN,
  localparam int IW   = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  me_edge_t         edges,
  input  logic [SAD_W-1:0] sad [N],
  output logic [SAD_W-1:0] best_sad,
  output logic [IW-1:0]    best_idx,
  output logic             done
);
  logic          busy;
  logic [IW-1:0] idx;
  logic [SAD_W-1:0] cur;
  logic          illegal;

  always_comb begin
    int cx;
    int cy;
    cx = int'(idx) % SPAN;
    cy = int'(idx) / SPAN;
    illegal = (edges.l && cx < RANGE) || (edges.r && cx > RANGE) ||
              (edges.t && cy < RANGE) || (edges.b && cy > RANGE);
    cur = illegal ? '1 : sad[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      idx      <= '0;
      done     <= 1'b0;
      best_sad <= '1;
      best_idx <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
      end else if (busy) begin
        // strict compare keeps the lowest index on ties
        if (idx == '0 || cur < best_sad) begin
          best_sad <= cur;
          best_idx <= idx;
        end
        if (idx == IW'(N-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sad_motion_est.sv
module sad_motion_est
  import sad_pkg::*;
#(
  parameter int BLK   = 16,
  parameter int RANGE = 8,
  parameter int PIX_W = 10,
  parameter int SAD_W = 19,
  localparam int VW   = $clog2(RANGE)+1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  output logic             win_ready,
  input  logic [PIX_W-1:0] win_pix,
  input  logic             ref_valid,
  output logic             ref_ready,
  input  logic [PIX_W-1:0] ref_pix,
  input  logic             edge_left,
  input  logic             edge_right,
  input  logic             edge_top,
  input  logic             edge_bottom,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [VW-1:0]    res_dx,
  output logic [VW-1:0]    res_dy,
  output logic [SAD_W-1:0] res_sad,
  output logic             res_dir
);
  localparam int SPAN = 2*RANGE;
  localparam int N    = SPAN*SPAN;
  localparam int WIN  = BLK+SPAN-1;
  localparam int WW   = WIN*WIN;
  localparam int AW   = $clog2(WW);
  localparam int XW   = $clog2(BLK);
  localparam int IW   = $clog2(N);
  localparam int LCW  = $clog2(2*WW);
  localparam int RCW  = $clog2(BLK*BLK);

  me_phase_e        phase_q;
  logic [LCW-1:0]   wcnt;
  logic [RCW-1:0]   rcnt;
  me_edge_t         edge_q;
  logic             win_fire, ref_fire, last_w, last_r;
  logic             sel_fwd;
  logic [AW-1:0]    waddr;
  logic [XW-1:0]    ref_x, ref_y;
  logic             clr;
  logic [SAD_W-1:0] b_sads [N];
  logic [SAD_W-1:0] f_sads [N];
  logic [SAD_W-1:0] b_best, f_best;
  logic [IW-1:0]    b_idx, f_idx;
  logic             b_done, f_done;
  logic             take_fwd;
  logic [IW-1:0]    pick_idx;

  assign win_ready = (phase_q == PH_LOAD);
  assign ref_ready = (phase_q == PH_REF);
  assign res_valid = (phase_q == PH_OUT);

  assign win_fire = win_valid && win_ready;
  assign ref_fire = ref_valid && ref_ready;
  assign last_w   = (wcnt == LCW'(2*WW-1));
  assign last_r   = (rcnt == RCW'(BLK*BLK-1));
  assign sel_fwd  = (wcnt >= LCW'(WW));
  assign waddr    = sel_fwd ? AW'(wcnt - LCW'(WW)) : AW'(wcnt);
  assign ref_x    = XW'(int'(rcnt) / BLK);
  assign ref_y    = XW'(int'(rcnt) % BLK);
  assign clr      = win_fire && last_w;

  sad_cand_array #(.BLK(BLK), .RANGE(RANGE), .PIX_W(PIX_W), .SAD_W(SAD_W)) u_bwd (
    .clk(clk), .rst_n(rst_n),
    .wr_en(win_fire && !sel_fwd), .wr_addr(waddr), .wr_pix(win_pix),
    .clr(clr), .acc_en(ref_fire), .ref_x(ref_x), .ref_y(ref_y),
    .ref_pix(ref_pix), .sad(b_sads)
  );

  sad_cand_array #(.BLK(BLK), .RANGE(RANGE), .PIX_W(PIX_W), .SAD_W(SAD_W)) u_fwd (
    .clk(clk), .rst_n(rst_n),
    .wr_en(win_fire && sel_fwd), .wr_addr(waddr), .wr_pix(win_pix),
    .clr(clr), .acc_en(ref_fire), .ref_x(ref_x), .ref_y(ref_y),
    .ref_pix(ref_pix), .sad(f_sads)
  );

  sad_min_scan #(.RANGE(RANGE), .SAD_W(SAD_W)) u_scan_b (
    .clk(clk), .rst_n(rst_n), .start(ref_fire && last_r), .edges(edge_q),
    .sad(b_sads), .best_sad(b_best), .best_idx(b_idx), .done(b_done)
  );

  sad_min_scan #(.RANGE(RANGE), .SAD_W(SAD_W)) u_scan_f (
    .clk(clk), .rst_n(rst_n), .start(ref_fire && last_r), .edges(edge_q),
    .sad(f_sads), .best_sad(f_best), .best_idx(f_idx), .done(f_done)
  );

  // backward wins ties between directions
  assign take_fwd = (f_best < b_best);
  assign pick_idx = take_fwd ? f_idx : b_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LOAD;
      wcnt    <= '0;
      rcnt    <= '0;
      edge_q  <= '0;
      res_dx  <= '0;
      res_dy  <= '0;
      res_sad <= '0;
      res_dir <= 1'b0;
    end else begin
      case (phase_q)
        PH_LOAD: if (win_fire) begin
          if (last_w) begin
            wcnt    <= '0;
            phase_q <= PH_REF;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        PH_REF: if (ref_fire) begin
          if (rcnt == '0) edge_q <= '{l: edge_left, r: edge_right, t: edge_top, b: edge_bottom};
          if (last_r) begin
            rcnt    <= '0;
            phase_q <= PH_SCAN;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        PH_SCAN: if (b_done && f_done) begin
          res_dir <= take_fwd;
          res_sad <= take_fwd ? f_best : b_best;
          res_dx  <= VW'(int'(pick_idx) % SPAN - RANGE);
          res_dy  <= VW'(int'(pick_idx) / SPAN - RANGE);
          phase_q <= PH_OUT;
        end
        PH_OUT: if (res_ready) phase_q <= PH_LOAD;
        default: phase_q <= PH_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/sad_motion_est_chk.sv
module sad_motion_est_chk
  import sad_pkg::*;
#(
  parameter int RANGE = 8,
  parameter int SAD_W = 19,
  localparam int VW   = $clog2(RANGE)+1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             win_ready,
  input logic             ref_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [VW-1:0]    res_dx,
  input logic [VW-1:0]    res_dy,
  input logic [SAD_W-1:0] res_sad,
  input logic             res_dir,
  input me_edge_t         edge_q,
  input logic [SAD_W-1:0] b_best,
  input logic [SAD_W-1:0] f_best
);
  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && !win_ready && $stable(res_sad) &&
      $stable(res_dx) && $stable(res_dy) && $stable(res_dir));

  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({win_ready, ref_ready, res_valid}) <= 1);

  // R6
  edge_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_sad != '1 &&
      !(edge_q.l && $signed(res_dx) < 0) && !(edge_q.r && $signed(res_dx) > 0) &&
      !(edge_q.t && $signed(res_dy) < 0) && !(edge_q.b && $signed(res_dy) > 0));

  // R7
  dir_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_sad <= b_best && res_sad <= f_best &&
      (res_dir ? (f_best < b_best) : (res_sad == b_best)));
endmodule

bind sad_motion_est sad_motion_est_chk #(.RANGE(RANGE), .SAD_W(SAD_W)) u_chk (.*);

// File: tb/tb_sad_motion_est.sv
module tb_sad_motion_est;
  localparam int CLK_PERIOD = 10;
  localparam int BLK   = 4;
  localparam int RANGE = 2;
  localparam int PIX_W = 8;
  localparam int SAD_W = 13;
  localparam int VW    = $clog2(RANGE)+1;
  localparam int SPAN  = 2*RANGE;
  localparam int WIN   = BLK+SPAN-1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_valid = 1'b0, ref_valid = 1'b0, res_ready = 1'b0;
  logic [PIX_W-1:0] win_pix = '0, ref_pix = '0;
  logic edge_left = 1'b0, edge_right = 1'b0, edge_top = 1'b0, edge_bottom = 1'b0;
  logic win_ready, ref_ready, res_valid, res_dir;
  logic [VW-1:0] res_dx, res_dy;
  logic [SAD_W-1:0] res_sad;

  int total = 0;
  int bad = 0;
  int seed = 12345;
  int wn [2][WIN][WIN];
  int rf [BLK][BLK];

  always #(CLK_PERIOD/2) clk = ~clk;

  sad_motion_est #(.BLK(BLK), .RANGE(RANGE), .PIX_W(PIX_W), .SAD_W(SAD_W)) dut (.*);

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8) & 255;
  endfunction

  task automatic fill_rand();
    for (int d = 0; d < 2; d++)
      for (int x = 0; x < WIN; x++)
        for (int y = 0; y < WIN; y++) wn[d][x][y] = rnd();
    for (int x = 0; x < BLK; x++)
      for (int y = 0; y < BLK; y++) rf[x][y] = rnd();
  endtask

  task automatic copy_ref(int d, int dx, int dy);
    for (int x = 0; x < BLK; x++)
      for (int y = 0; y < BLK; y++) rf[x][y] = wn[d][x+dx+RANGE][y+dy+RANGE];
  endtask

  task automatic model(output int edx, output int edy, output int esad, output int edir);
    int bs [2];
    int bk [2];
    for (int d = 0; d < 2; d++) begin
      bs[d] = (1 << SAD_W) - 1; bk[d] = 0;
      for (int k = 0; k < SPAN*SPAN; k++) begin
        int cx, cy, s;
        cx = k % SPAN; cy = k / SPAN;
        s = 0;
        if (!((edge_left && cx < RANGE) || (edge_right && cx > RANGE) ||
              (edge_top && cy < RANGE) || (edge_bottom && cy > RANGE))) begin
          for (int x = 0; x < BLK; x++)
            for (int y = 0; y < BLK; y++) begin
              int df;
              df = rf[x][y] - wn[d][x+cx][y+cy];
              s += (df < 0) ? -df : df;
            end
          if (s < bs[d]) begin bs[d] = s; bk[d] = k; end
        end
      end
    end
    edir = (bs[1] < bs[0]) ? 1 : 0;
    esad = bs[edir];
    edx = bk[edir] % SPAN - RANGE;
    edy = bk[edir] / SPAN - RANGE;
  endtask

  // stream windows and reference, then collect and compare the result
  task automatic run_block(string name, bit gaps, int hold);
    int edx, edy, esad, edir, sdx, ssad;
    model(edx, edy, esad, edir);
    for (int j = 0; j < 2*WIN*WIN; j++) begin
      @(negedge clk);
      if (gaps && (j % 3 == 0)) begin win_valid = 1'b0; @(negedge clk); end
      win_valid = 1'b1;
      win_pix = PIX_W'(wn[j / (WIN*WIN)][(j % (WIN*WIN)) / WIN][j % WIN]);
      while (!win_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); win_valid = 1'b0;
    chk({name, " R3 ref_ready after load"}, int'(ref_ready), 1);
    chk({name, " R2 win_ready low in ref phase"}, int'(win_ready), 0);
    for (int i = 0; i < BLK*BLK; i++) begin
      if (i != 0) @(negedge clk);
      if (gaps && (i % 2 == 1)) begin ref_valid = 1'b0; @(negedge clk); end
      ref_valid = 1'b1;
      ref_pix = PIX_W'(rf[i / BLK][i % BLK]);
      while (!ref_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); ref_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    sdx = $signed(res_dx); ssad = int'(res_sad);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk({name, " R8 valid held"}, int'(res_valid), 1);
      chk({name, " R8 sad stable"}, int'(res_sad), ssad);
      chk({name, " R8 dx stable"}, $signed(res_dx), sdx);
      chk({name, " R8 no window accept"}, int'(win_ready), 0);
    end
    chk({name, " R5 dx"}, $signed(res_dx), edx);
    chk({name, " R5 dy"}, $signed(res_dy), edy);
    chk({name, " R4 sad"}, int'(res_sad), esad);
    chk({name, " R7 dir"}, int'(res_dir), edir);
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
    chk({name, " R2 window phase again"}, int'(win_ready), 1);
  endtask

  task automatic set_edges(bit l, bit r, bit t, bit b);
    edge_left = l; edge_right = r; edge_top = t; edge_bottom = b;
  endtask

  task automatic t_reset();
    chk("R1 res_valid", int'(res_valid), 0);
    chk("R1 win_ready", int'(win_ready), 1);
    chk("R1 ref_ready", int'(ref_ready), 0);
  endtask

  task automatic t_match_fwd();
    set_edges(0, 0, 0, 0);
    fill_rand(); copy_ref(1, 1, -1);
    run_block("match_fwd", 1'b0, 0);
    chk("match_fwd R4 zero sad", int'(res_sad), 0);
    chk("match_fwd R7 forward", int'(res_dir), 1);
  endtask

  task automatic t_tie();
    set_edges(0, 0, 0, 0);
    for (int d = 0; d < 2; d++)
      for (int x = 0; x < WIN; x++)
        for (int y = 0; y < WIN; y++) wn[d][x][y] = 50;
    for (int x = 0; x < BLK; x++)
      for (int y = 0; y < BLK; y++) rf[x][y] = 60;
    run_block("tie", 1'b0, 0);
    chk("tie R5 lowest index dx", $signed(res_dx), -RANGE);
    chk("tie R7 backward on tie", int'(res_dir), 0);
  endtask

  task automatic t_edge_left();
    set_edges(1, 0, 0, 0);
    fill_rand(); copy_ref(0, -1, 0);
    for (int x = 0; x < WIN; x++)
      for (int y = 0; y < WIN; y++) wn[1][x][y] = 255 - wn[0][x][y];
    run_block("edge_left", 1'b0, 0);
    chk("edge_left R6 dx not negative", int'($signed(res_dx) >= 0), 1);
  endtask

  task automatic t_edge_all();
    set_edges(1, 1, 1, 1);
    fill_rand();
    run_block("edge_all", 1'b0, 0);
    chk("edge_all R6 dx zero", $signed(res_dx), 0);
    chk("edge_all R6 dy zero", $signed(res_dy), 0);
  endtask

  task automatic t_scene_cut();
    set_edges(0, 0, 0, 0);
    fill_rand(); copy_ref(0, 0, 1);
    for (int x = 0; x < WIN; x++)
      for (int y = 0; y < WIN; y++) wn[1][x][y] = (x + y) % 2 == 0 ? 255 : 0;
    run_block("scene_cut", 1'b0, 0);
    chk("scene_cut R7 backward", int'(res_dir), 0);
    chk("scene_cut R5 dy", $signed(res_dy), 1);
  endtask

  task automatic t_max_acc();
    set_edges(0, 0, 0, 0);
    for (int d = 0; d < 2; d++)
      for (int x = 0; x < WIN; x++)
        for (int y = 0; y < WIN; y++) wn[d][x][y] = 0;
    for (int x = 0; x < BLK; x++)
      for (int y = 0; y < BLK; y++) rf[x][y] = 255;
    run_block("max_acc", 1'b0, 0);
    chk("max_acc R4 full sum", int'(res_sad), BLK*BLK*255);
  endtask

  task automatic t_stall();
    set_edges(0, 1, 0, 1);
    fill_rand(); copy_ref(1, -2, -1);
    run_block("stall R9", 1'b1, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_match_fwd();
    t_tie();
    t_edge_left();
    t_edge_all();
    t_scene_cut();
    t_max_acc();
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule